// File: doc/BRIEF.md
# DMA Sync-Mode Transfer Request Sequencer

This block holds the parameter entry of one DMA channel and turns synchronization events into transfer requests (TRs) for a downstream transfer engine. The entry holds a source address, a destination address, an element count, a frame (array) count, an element index and a frame index. It is written in one cycle through a load strobe. Each accepted sync event produces one TR descriptor on a valid/ready port. The descriptor carries the source, destination, byte count, array count and array index, so the engine needs nothing else to run it.

A 2-bit sync mode sets how much data one TR covers: a single element, a frame of spaced elements, an array of contiguous elements, or the whole entry at once. After each accepted TR the block advances the address and count fields that belong to that mode. When the last TR of the entry is accepted, the block pulses a done flag. It then ignores further events until the entry is loaded again. One event may wait while a TR is outstanding. Further events set a sticky missed flag.

Top module: `dma_tr_seq`

## Requirements
- R1: After reset trValid, done and missed are 0, and sync events are ignored (trValid stays 0) until the first load.
- R2: Mode 2'b00 (element): each TR has trBytes = ELEM_BYTES, trArrCnt = 1, trArrIdx = 0. After an accepted TR both addresses step by the element index and the element count decrements. After the last element of a frame, both addresses step by the frame index instead, the element count reloads and the frame count decrements.
- R3: Mode 2'b01 (frame): each TR has trBytes = ELEM_BYTES, trArrCnt = element count, trArrIdx = element index. After acceptance both addresses step by the frame index and the frame count decrements.
- R4: Mode 2'b10 (array): each TR has trBytes = element count × ELEM_BYTES, trArrCnt = 1, trArrIdx = 0. After acceptance both addresses step by the frame index and the frame count decrements.
- R5: Mode 2'b11 (block): a single TR has trBytes = element count × ELEM_BYTES, trArrCnt = frame count, trArrIdx = frame index. No address or count changes afterwards, so a reload reissues the same descriptor.
- R6: While trValid is 1 and trReady is 0, trValid stays 1 and the descriptor holds its value.
- R7: A sync event that arrives while a TR is outstanding is held. When that TR is accepted, the next TR is presented with trValid held high, carrying the advanced addresses.
- R8: A sync event that arrives while one is already held sets missed. missed stays set until the next load.
- R9: In the cycle after the final TR is accepted, done is 1 for exactly one cycle and trValid is 0.
- R10: Once the entry is exhausted, sync events produce no TR.
- R11: A load drops any outstanding TR and any held event, clears missed, and re-arms the channel with the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Writes the cfg* values into the entry and re-arms |
| cfgMode | input | 2 | Sync mode: 00 element, 01 frame, 10 array, 11 block |
| cfgSrc | input | ADDR_W | Initial source address |
| cfgDst | input | ADDR_W | Initial destination address |
| cfgElemCnt | input | CNT_W | Elements per frame/array (at least 1) |
| cfgFrmCnt | input | CNT_W | Frames/arrays in the entry (at least 1) |
| cfgElemIdx | input | IDX_W | Byte step between elements |
| cfgFrmIdx | input | IDX_W | Byte step between frames/arrays |
| syncEvt | input | 1 | Synchronization event, one cycle per event |
| trValid | output | 1 | TR descriptor valid |
| trReady | input | 1 | Transfer engine accepts the descriptor |
| trSrc | output | ADDR_W | TR source address |
| trDst | output | ADDR_W | TR destination address |
| trBytes | output | CNT_W+$clog2(ELEM_BYTES) | Bytes per array |
| trArrCnt | output | CNT_W | Arrays in this TR |
| trArrIdx | output | IDX_W | Byte step between arrays |
| done | output | 1 | One-cycle pulse when the entry is exhausted |
| missed | output | 1 | Sticky flag: an event was lost |

## Verification
The element-mode test runs two frames so that the frame boundary appears. A design that always stepped by the element index would present the third TR at the wrong address. The backpressure test holds trReady low with a second event pending. A design that dropped the held event would leave trValid low after the first acceptance, and one that queued without limit would never raise missed. After the last array and after the single block TR, further events are sent. A design that kept counting or wrapped would present a new TR. Reloading a block entry must reissue the identical descriptor, which exposes any address update in that mode.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SYNC_ELEM  = 2'b00,
    SYNC_FRAME = 2'b01,
    SYNC_ARRAY = 2'b10,
    SYNC_BLOCK = 2'b11
  } syncMode_e;

  typedef struct packed {
    logic load;
    logic adv;
  } seqStrobe_t;
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 16,
  parameter int ELEM_BYTES = 4,
  localparam int BYTE_W    = CNT_W + $clog2(ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgElemCnt,
  input  logic [CNT_W-1:0]  cfgFrmCnt,
  input  logic [IDX_W-1:0]  cfgElemIdx,
  input  logic [IDX_W-1:0]  cfgFrmIdx,
  output logic              lastTr,
  output logic [ADDR_W-1:0] trSrc,
  output logic [ADDR_W-1:0] trDst,
  output logic [BYTE_W-1:0] trBytes,
  output logic [CNT_W-1:0]  trArrCnt,
  output logic [IDX_W-1:0]  trArrIdx
);
  syncMode_e         mode;
  logic [ADDR_W-1:0] srcQ, dstQ;
  logic [CNT_W-1:0]  elemCnt, frmCnt, elemLeft, frmLeft;
  logic [IDX_W-1:0]  elemIdx, frmIdx;
  logic              elemLast, frmLast;
  logic [BYTE_W-1:0] arrBytes;

  assign elemLast = (elemLeft == CNT_W'(1));
  assign frmLast  = (frmLeft == CNT_W'(1));
  assign arrBytes = BYTE_W'(elemCnt) * BYTE_W'(ELEM_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= SYNC_ELEM;
      srcQ     <= '0;
      dstQ     <= '0;
      elemCnt  <= '0;
      frmCnt   <= '0;
      elemLeft <= '0;
      frmLeft  <= '0;
      elemIdx  <= '0;
      frmIdx   <= '0;
    end else if (stb.load) begin
      mode     <= syncMode_e'(cfgMode);
      srcQ     <= cfgSrc;
      dstQ     <= cfgDst;
      elemCnt  <= cfgElemCnt;
      frmCnt   <= cfgFrmCnt;
      elemLeft <= cfgElemCnt;
      frmLeft  <= cfgFrmCnt;
      elemIdx  <= cfgElemIdx;
      frmIdx   <= cfgFrmIdx;
    end else if (stb.adv) begin
      case (mode)
        SYNC_ELEM: begin
          if (elemLast) begin
            elemLeft <= elemCnt;
            frmLeft  <= frmLeft - CNT_W'(1);
            srcQ     <= srcQ + ADDR_W'(frmIdx);
            dstQ     <= dstQ + ADDR_W'(frmIdx);
          end else begin
            elemLeft <= elemLeft - CNT_W'(1);
            srcQ     <= srcQ + ADDR_W'(elemIdx);
            dstQ     <= dstQ + ADDR_W'(elemIdx);
          end
        end
        SYNC_FRAME, SYNC_ARRAY: begin
          frmLeft <= frmLeft - CNT_W'(1);
          srcQ    <= srcQ + ADDR_W'(frmIdx);
          dstQ    <= dstQ + ADDR_W'(frmIdx);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    trSrc = srcQ;
    trDst = dstQ;
    case (mode)
      SYNC_ELEM: begin
        trBytes  = BYTE_W'(ELEM_BYTES);
        trArrCnt = CNT_W'(1);
        trArrIdx = '0;
        lastTr   = elemLast && frmLast;
      end
      SYNC_FRAME: begin
        trBytes  = BYTE_W'(ELEM_BYTES);
        trArrCnt = elemCnt;
        trArrIdx = elemIdx;
        lastTr   = frmLast;
      end
      SYNC_ARRAY: begin
        trBytes  = arrBytes;
        trArrCnt = CNT_W'(1);
        trArrIdx = '0;
        lastTr   = frmLast;
      end
      default: begin
        trBytes  = arrBytes;
        trArrCnt = frmCnt;
        trArrIdx = frmIdx;
        lastTr   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       syncEvt,
  input  logic       trReady,
  input  logic       lastTr,
  output seqStrobe_t stb,
  output logic       trValid,
  output logic       done,
  output logic       missed
);
  logic armed, pending, hs;

  assign hs       = trValid && trReady;
  assign stb.load = load;
  assign stb.adv  = hs && !load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      trValid <= 1'b0;
      pending <= 1'b0;
      missed  <= 1'b0;
      done    <= 1'b0;
    end else if (load) begin
      armed   <= 1'b1;
      trValid <= 1'b0;
      pending <= 1'b0;
      missed  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= hs && lastTr;
      if (hs) begin
        if (lastTr) begin
          armed   <= 1'b0;
          trValid <= 1'b0;
          pending <= 1'b0;
        end else begin
          trValid <= pending || syncEvt;
          pending <= pending && syncEvt;
        end
      end else if (trValid) begin
        if (syncEvt) begin
          if (pending) missed <= 1'b1;
          else         pending <= 1'b1;
        end
      end else if (armed && syncEvt) begin
        trValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_tr_seq.sv
module dma_tr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 16,
  parameter int ELEM_BYTES = 4,
  localparam int BYTE_W    = CNT_W + $clog2(ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgElemCnt,
  input  logic [CNT_W-1:0]  cfgFrmCnt,
  input  logic [IDX_W-1:0]  cfgElemIdx,
  input  logic [IDX_W-1:0]  cfgFrmIdx,
  input  logic              syncEvt,
  output logic              trValid,
  input  logic              trReady,
  output logic [ADDR_W-1:0] trSrc,
  output logic [ADDR_W-1:0] trDst,
  output logic [BYTE_W-1:0] trBytes,
  output logic [CNT_W-1:0]  trArrCnt,
  output logic [IDX_W-1:0]  trArrIdx,
  output logic              done,
  output logic              missed
);
  seqStrobe_t stb;
  logic       lastTr;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .load(load), .syncEvt(syncEvt),
    .trReady(trReady), .lastTr(lastTr), .stb(stb),
    .trValid(trValid), .done(done), .missed(missed)
  );

  dma_seq_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .ELEM_BYTES(ELEM_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgMode(cfgMode),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgElemCnt(cfgElemCnt),
    .cfgFrmCnt(cfgFrmCnt), .cfgElemIdx(cfgElemIdx), .cfgFrmIdx(cfgFrmIdx),
    .lastTr(lastTr), .trSrc(trSrc), .trDst(trDst), .trBytes(trBytes),
    .trArrCnt(trArrCnt), .trArrIdx(trArrIdx)
  );
endmodule

// File: rtl/dma_tr_seq_chk.sv
module dma_tr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              load,
  input logic              trValid,
  input logic              trReady,
  input logic [ADDR_W-1:0] trSrc,
  input logic [ADDR_W-1:0] trDst,
  input logic [BYTE_W-1:0] trBytes,
  input logic              done,
  input logic              missed
);
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    trValid && !trReady && !load |=>
      trValid && $stable(trSrc) && $stable(trDst) && $stable(trBytes));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !trValid);

  p_missed_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    missed && !load |=> missed);

  p_load_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !trValid && !missed && !done);
endmodule

bind dma_tr_seq dma_tr_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .load(load), .trValid(trValid), .trReady(trReady),
  .trSrc(trSrc), .trDst(trDst), .trBytes(trBytes), .done(done), .missed(missed)
);

// File: tb/dma_tr_seq_test.sv
module dma_tr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, IW = 16, EB = 4;
  localparam int BW = CW + $clog2(EB);

  logic clk = 1'b0, rstN = 1'b0, load = 1'b0, syncEvt = 1'b0, trReady = 1'b0;
  logic [1:0] cfgMode = '0;
  logic [AW-1:0] cfgSrc = '0, cfgDst = '0;
  logic [CW-1:0] cfgElemCnt = '0, cfgFrmCnt = '0;
  logic [IW-1:0] cfgElemIdx = '0, cfgFrmIdx = '0;
  logic trValid, done, missed;
  logic [AW-1:0] trSrc, trDst;
  logic [BW-1:0] trBytes;
  logic [CW-1:0] trArrCnt;
  logic [IW-1:0] trArrIdx;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_tr_seq #(.ADDR_W(AW), .CNT_W(CW), .IDX_W(IW), .ELEM_BYTES(EB)) uut (
    .clk(clk), .rstN(rstN), .load(load), .cfgMode(cfgMode), .cfgSrc(cfgSrc),
    .cfgDst(cfgDst), .cfgElemCnt(cfgElemCnt), .cfgFrmCnt(cfgFrmCnt),
    .cfgElemIdx(cfgElemIdx), .cfgFrmIdx(cfgFrmIdx), .syncEvt(syncEvt),
    .trValid(trValid), .trReady(trReady), .trSrc(trSrc), .trDst(trDst),
    .trBytes(trBytes), .trArrCnt(trArrCnt), .trArrIdx(trArrIdx),
    .done(done), .missed(missed)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadEntry(logic [1:0] m, logic [AW-1:0] s, logic [AW-1:0] d,
                           int ec, int fc, int ei, int fi);
    @(negedge clk);
    cfgMode = m; cfgSrc = s; cfgDst = d;
    cfgElemCnt = CW'(ec); cfgFrmCnt = CW'(fc);
    cfgElemIdx = IW'(ei); cfgFrmIdx = IW'(fi);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk) syncEvt = 1'b1;
    @(negedge clk) syncEvt = 1'b0;
  endtask

  task automatic expectTr(string tag, logic [AW-1:0] s, logic [AW-1:0] d,
                          int by, int ac, int ai);
    check({tag, " trValid"}, 64'(trValid), 64'd1);
    check({tag, " trSrc"}, 64'(trSrc), 64'(s));
    check({tag, " trDst"}, 64'(trDst), 64'(d));
    check({tag, " trBytes"}, 64'(trBytes), 64'(by));
    check({tag, " trArrCnt"}, 64'(trArrCnt), 64'(ac));
    check({tag, " trArrIdx"}, 64'(trArrIdx), 64'(ai));
  endtask

  task automatic accept();
    trReady = 1'b1;
    @(negedge clk);
    trReady = 1'b0;
  endtask

  task automatic testReset();
    check("R1 trValid after reset", 64'(trValid), 64'd0);
    check("R1 done after reset", 64'(done), 64'd0);
    check("R1 missed after reset", 64'(missed), 64'd0);
    pulseSync();
    check("R1 sync before load ignored", 64'(trValid), 64'd0);
  endtask

  task automatic testElement();
    loadEntry(2'b00, 32'h1000, 32'h2000, 2, 2, 4, 'h100);
    pulseSync(); expectTr("R2 elem0", 32'h1000, 32'h2000, 4, 1, 0); accept();
    pulseSync(); expectTr("R2 elem1", 32'h1004, 32'h2004, 4, 1, 0); accept();
    check("R9 no done mid-entry", 64'(done), 64'd0);
    pulseSync(); expectTr("R2 frame step", 32'h1104, 32'h2104, 4, 1, 0); accept();
    pulseSync(); expectTr("R2 elem3", 32'h1108, 32'h2108, 4, 1, 0); accept();
    check("R9 done pulse", 64'(done), 64'd1);
    check("R9 trValid low at done", 64'(trValid), 64'd0);
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic testFrame();
    loadEntry(2'b01, 32'h100, 32'h800, 3, 2, 8, 'h40);
    pulseSync(); expectTr("R3 frame0", 32'h100, 32'h800, 4, 3, 8); accept();
    pulseSync(); expectTr("R3 frame1", 32'h140, 32'h840, 4, 3, 8); accept();
    check("R3 done after last frame", 64'(done), 64'd1);
  endtask

  task automatic testArray();
    loadEntry(2'b10, 32'h3000, 32'h4000, 5, 3, 0, 'h20);
    pulseSync(); expectTr("R4 arr0", 32'h3000, 32'h4000, 20, 1, 0); accept();
    pulseSync(); expectTr("R4 arr1", 32'h3020, 32'h4020, 20, 1, 0); accept();
    pulseSync(); expectTr("R4 arr2", 32'h3040, 32'h4040, 20, 1, 0); accept();
    check("R4 done", 64'(done), 64'd1);
    pulseSync();
    check("R10 no TR after exhaustion", 64'(trValid), 64'd0);
  endtask

  task automatic testBlock();
    loadEntry(2'b11, 32'h5000, 32'h6000, 4, 3, 0, 'h80);
    pulseSync(); expectTr("R5 block", 32'h5000, 32'h6000, 16, 3, 'h80); accept();
    check("R5 done after single TR", 64'(done), 64'd1);
    pulseSync();
    check("R10 block exhausted", 64'(trValid), 64'd0);
    loadEntry(2'b11, 32'h5000, 32'h6000, 4, 3, 0, 'h80);
    pulseSync(); expectTr("R11 R5 reload reissues", 32'h5000, 32'h6000, 16, 3, 'h80);
    accept();
  endtask

  task automatic testBackpressure();
    loadEntry(2'b10, 32'h0, 32'h100, 1, 4, 0, 'h10);
    pulseSync();
    pulseSync();
    for (int i = 0; i < 3; i++) begin
      expectTr("R6 held", 32'h0, 32'h100, 4, 1, 0);
      @(negedge clk);
    end
    check("R8 no missed with one pending", 64'(missed), 64'd0);
    accept();
    expectTr("R7 pending issued", 32'h10, 32'h110, 4, 1, 0);
    pulseSync();
    pulseSync();
    check("R8 missed set", 64'(missed), 64'd1);
    accept();
    expectTr("R7 second pending", 32'h20, 32'h120, 4, 1, 0);
    accept();
    check("R7 no extra TR", 64'(trValid), 64'd0);
    check("R8 missed sticky", 64'(missed), 64'd1);
    pulseSync();
    check("R11 outstanding before load", 64'(trValid), 64'd1);
    loadEntry(2'b10, 32'h0, 32'h100, 1, 4, 0, 'h10);
    check("R11 load clears missed", 64'(missed), 64'd0);
    check("R11 load drops TR", 64'(trValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testElement();
    testFrame();
    testArray();
    testBlock();
    testBackpressure();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule